// File: doc/BRIEF.md
# Processor Poll and Reset Responder

This block is the responder for a single processing unit. It watches privileged I/O control words from a processor interface and acts on three operations that share one opcode: a reset of the unit's attached devices, a poll of the unit's fault status, and a poll that also clears that status. Each word carries a cluster address and a unit address. The block compares them with an address strapped on its own input pins. A word that does not address this unit, or that carries an unknown operation, is answered with a not-recognized code and changes nothing.

Fault inputs set bits in a 16-bit fault status register. A poll reports that register in both halves of a 32-bit result word, together with a three-bit condition code that tells whether a fault interrupt is pending. A parity error on the returned status is modelled by an injected error input, which is sampled with the command. Commands are accepted on a valid/ready handshake. The condition code and result word appear one cycle after acceptance, qualified by a done strobe.

Top module: `pollrst_responder`

## Requirements
- R1: Bit 0 is the most significant bit of the command word. The opcode is in bits 1 to 7 (`cmd_word[30:24]`) and must equal 7'h4F. The operation is in bits 15 to 17 (`cmd_word[16:14]`), the cluster address in bits 18 to 20 (`cmd_word[13:11]`) and the unit address in bits 21 to 23 (`cmd_word[10:8]`). All other bits are ignored.
- R2: A word addresses this unit when its cluster field equals `my_cluster` and its unit field equals `my_unit`. When the cluster field is 7, the unit field is not compared.
- R3: Operation 3'b001 (reset), when recognized, returns condition code 3'b000 and result word 0. It drives `io_reset_out` high for exactly one cycle, in the same cycle as `rsp_done`.
- R4: Operation 3'b010 (poll), when recognized, returns condition code 3'b000 if the fault status is zero and 3'b010 if it is nonzero. The result word is {status, status}, and the status is left unchanged.
- R5: Operation 3'b011 (poll and clear), when recognized, returns the same code and word as a poll and then clears the fault status.
- R6: A word that is not recognized returns condition code 3'b110 and result word 0. This covers a wrong opcode, an address mismatch, or an operation other than 001, 010 or 011. Such a word gives no reset pulse and leaves the status unchanged. `parity_err` has no effect on it.
- R7: If `parity_err` is high when a recognized command is accepted, the condition code is 3'b101. The reset pulse or the status clear still takes place.
- R8: Every cycle, the bits of `fault_set` are ORed into the fault status. A bit set in the same cycle as a clear survives the clear. A poll reports the status as it was before the accepting clock edge.
- R9: `cmd_ready` is high whenever the block is out of reset. A command is accepted when `cmd_valid` and `cmd_ready` are both high. Each accepted command raises `rsp_done` for the following cycle only, so back-to-back commands give back-to-back strobes. `rsp_cc` and `rsp_word` hold their values between strobes.
- R10: While `rst_n` is low, `rsp_done`, `io_reset_out`, `rsp_cc`, `rsp_word` and the fault status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_cluster | input | 3 | Strapped cluster address of this unit |
| my_unit | input | 3 | Strapped unit address of this unit |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Responder can accept a command |
| cmd_word | input | 32 | Control instruction word (bit 0 = MSB) |
| parity_err | input | 1 | Injected parity error on returned status |
| fault_set | input | 16 | Fault event bits ORed into the status register |
| rsp_done | output | 1 | Response strobe, one cycle after acceptance |
| rsp_cc | output | 3 | Condition code |
| rsp_word | output | 32 | Result word, status in both halves |
| io_reset_out | output | 1 | One-cycle I/O reset toward attached devices |

## Verification
The hardest case to reach is a fault arriving in the very cycle a poll-and-clear is accepted. The bench gets there by driving `fault_set` alongside the command word, both in a directed test and throughout the sweep. A later poll then shows that the new bit survived while the older bits were cleared. The sweep covers every cluster, unit and operation value against several strapped addresses, including cluster 7. Fault injection and parity errors are interleaved on fixed strides, so the status register holds a changing mix of zero and nonzero values when polls arrive.

// File: rtl/pollrst_pkg.sv
package pollrst_pkg;

   localparam int FN_W = 3;
   localparam int CC_W = 3;

   localparam logic [FN_W-1:0] FN_RESET    = 3'b001;
   localparam logic [FN_W-1:0] FN_POLL     = 3'b010;
   localparam logic [FN_W-1:0] FN_POLL_CLR = 3'b011;

   localparam logic [CC_W-1:0] CC_OK     = 3'b000;
   localparam logic [CC_W-1:0] CC_PEND   = 3'b010;
   localparam logic [CC_W-1:0] CC_PARITY = 3'b101;
   localparam logic [CC_W-1:0] CC_NOADDR = 3'b110;

   typedef struct packed {
      logic hit;
      logic do_reset;
      logic do_poll;
      logic do_clear;
   } cmd_dec_t;

endpackage

// File: rtl/pollrst_decode.sv
module pollrst_decode
   import pollrst_pkg::*;
#(
   parameter int              WORD_W       = 32,
   parameter int              ADDR_W       = 3,
   parameter int              OPC_W        = 7,
   parameter logic [OPC_W-1:0] OPCODE      = 7'h4F,
   parameter bit              CHECK_OPCODE = 1'b1,
   parameter int              OPC_MSB0     = 1,
   parameter int              FN_MSB0      = 15,
   parameter int              CA_MSB0      = 18,
   parameter int              UA_MSB0      = 21
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [ADDR_W-1:0] my_cluster_i,
   input  logic [ADDR_W-1:0] my_unit_i,
   output cmd_dec_t          dec_o
);

   localparam int OPC_HI = WORD_W - 1 - OPC_MSB0;
   localparam int FN_HI  = WORD_W - 1 - FN_MSB0;
   localparam int CA_HI  = WORD_W - 1 - CA_MSB0;
   localparam int UA_HI  = WORD_W - 1 - UA_MSB0;
   localparam logic [ADDR_W-1:0] CA_SYSTEM = '1;

   logic [FN_W-1:0]   fn;
   logic [ADDR_W-1:0] ca;
   logic [ADDR_W-1:0] ua;
   logic              opc_ok;
   logic              addr_ok;
   logic              fn_ok;
   logic              unused_word;

   assign fn = word_i[FN_HI -: FN_W];
   assign ca = word_i[CA_HI -: ADDR_W];
   assign ua = word_i[UA_HI -: ADDR_W];
   assign unused_word = ^word_i;

   generate
      if (CHECK_OPCODE) begin : g_opc_cmp
         assign opc_ok = (word_i[OPC_HI -: OPC_W] == OPCODE);
      end else begin : g_opc_pass
         assign opc_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      addr_ok = (ca == my_cluster_i) && ((ca == CA_SYSTEM) || (ua == my_unit_i));
      fn_ok   = (fn == FN_RESET) || (fn == FN_POLL) || (fn == FN_POLL_CLR);
      dec_o.hit      = opc_ok && addr_ok && fn_ok;
      dec_o.do_reset = dec_o.hit && (fn == FN_RESET);
      dec_o.do_poll  = dec_o.hit && ((fn == FN_POLL) || (fn == FN_POLL_CLR));
      dec_o.do_clear = dec_o.hit && (fn == FN_POLL_CLR);
   end

endmodule

// File: rtl/pollrst_fault_reg.sv
module pollrst_fault_reg #(
   parameter int STATUS_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STATUS_W-1:0] set_i,
   input  logic                clr_i,
   output logic [STATUS_W-1:0] status_o
);

   generate
      for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               status_o[b] <= 1'b0;
            end else begin
               status_o[b] <= (status_o[b] && !clr_i) || set_i[b];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pollrst_resp.sv
module pollrst_resp
   import pollrst_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int STATUS_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept_i,
   input  cmd_dec_t            dec_i,
   input  logic                perr_i,
   input  logic [STATUS_W-1:0] status_i,
   output logic                done_o,
   output logic [CC_W-1:0]     cc_o,
   output logic [WORD_W-1:0]   word_o,
   output logic                io_reset_o
);

   logic [CC_W-1:0]   cc_next;
   logic [WORD_W-1:0] word_next;

   always_comb begin
      if (!dec_i.hit) begin
         cc_next = CC_NOADDR;
      end else if (perr_i) begin
         cc_next = CC_PARITY;
      end else if (dec_i.do_poll && (status_i != '0)) begin
         cc_next = CC_PEND;
      end else begin
         cc_next = CC_OK;
      end
      word_next = dec_i.do_poll ? {status_i, status_i} : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o     <= 1'b0;
         io_reset_o <= 1'b0;
         cc_o       <= '0;
         word_o     <= '0;
      end else begin
         done_o     <= accept_i;
         io_reset_o <= accept_i && dec_i.do_reset;
         if (accept_i) begin
            cc_o   <= cc_next;
            word_o <= word_next;
         end
      end
   end

endmodule

// File: rtl/pollrst_responder.sv
module pollrst_responder
   import pollrst_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int STATUS_W     = 16,
   parameter int ADDR_W       = 3,
   parameter int OPC_W        = 7,
   parameter logic [OPC_W-1:0] OPCODE = 7'h4F,
   parameter bit CHECK_OPCODE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   my_cluster,
   input  logic [ADDR_W-1:0]   my_unit,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [WORD_W-1:0]   cmd_word,
   input  logic                parity_err,
   input  logic [STATUS_W-1:0] fault_set,
   output logic                rsp_done,
   output logic [CC_W-1:0]     rsp_cc,
   output logic [WORD_W-1:0]   rsp_word,
   output logic                io_reset_out
);

   localparam int UA_MSB0 = 21;

   generate
      if (WORD_W != 2 * STATUS_W) begin : g_bad_width
         $error("pollrst_responder: WORD_W must be twice STATUS_W");
      end
      if (UA_MSB0 + ADDR_W > WORD_W) begin : g_bad_addr
         $error("pollrst_responder: address fields exceed the word");
      end
   endgenerate

   cmd_dec_t            dec;
   logic                accept;
   logic [STATUS_W-1:0] status;

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_ready <= 1'b0;
      else        cmd_ready <= 1'b1;
   end

   assign accept = cmd_valid && cmd_ready;

   pollrst_decode #(
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W), .OPCODE(OPCODE),
      .CHECK_OPCODE(CHECK_OPCODE), .OPC_MSB0(1), .FN_MSB0(15),
      .CA_MSB0(18), .UA_MSB0(UA_MSB0)
   ) u_decode (
      .word_i(cmd_word), .my_cluster_i(my_cluster), .my_unit_i(my_unit),
      .dec_o(dec)
   );

   pollrst_fault_reg #(.STATUS_W(STATUS_W)) u_fault (
      .clk(clk), .rst_n(rst_n), .set_i(fault_set),
      .clr_i(accept && dec.do_clear), .status_o(status)
   );

   pollrst_resp #(.WORD_W(WORD_W), .STATUS_W(STATUS_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .dec_i(dec),
      .perr_i(parity_err), .status_i(status), .done_o(rsp_done),
      .cc_o(rsp_cc), .word_o(rsp_word), .io_reset_o(io_reset_out)
   );

endmodule

// File: rtl/pollrst_checker.sv
module pollrst_checker #(
   parameter int WORD_W   = 32,
   parameter int STATUS_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              rsp_done,
   input logic [2:0]        rsp_cc,
   input logic [WORD_W-1:0] rsp_word,
   input logic              io_reset_out
);

   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> rsp_done);                                  // R9
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) |=> !rsp_done);                                // R9
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> ($stable(rsp_cc) && $stable(rsp_word)));                   // R9
   AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_cc == 3'b000 || rsp_cc == 3'b010 ||
                    rsp_cc == 3'b101 || rsp_cc == 3'b110));                    // R4
   AST_RESET_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      io_reset_out |-> (rsp_done && (rsp_cc == 3'b000 || rsp_cc == 3'b101)));  // R3
   AST_NOADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_cc == 3'b110) |-> (!io_reset_out && rsp_word == '0));   // R6
   AST_HALVES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_word[WORD_W-1:STATUS_W] == rsp_word[STATUS_W-1:0]));   // R4
   AST_PENDING_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_cc == 3'b010) |-> (rsp_word != '0));                    // R4
   AST_CLEAR_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_cc == 3'b000) |-> (rsp_word == '0));                    // R4

endmodule

bind pollrst_responder pollrst_checker #(.WORD_W(WORD_W), .STATUS_W(STATUS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .rsp_done(rsp_done), .rsp_cc(rsp_cc), .rsp_word(rsp_word),
   .io_reset_out(io_reset_out)
);

// File: tb/pollrst_responder_test.sv
`timescale 1ns/1ps
module pollrst_responder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  my_cluster = 3'd2;
   logic [2:0]  my_unit = 3'd4;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_word = '0;
   logic        parity_err = 1'b0;
   logic [15:0] fault_set = '0;
   logic        rsp_done;
   logic [2:0]  rsp_cc;
   logic [31:0] rsp_word;
   logic        io_reset_out;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit finished = 1'b0;

   logic [15:0] st = '0;
   logic [2:0]  last_cc = '0;
   logic [31:0] last_word = '0;

   always #10 clk = ~clk;

   pollrst_responder uut (
      .clk(clk), .rst_n(rst_n), .my_cluster(my_cluster), .my_unit(my_unit),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
      .parity_err(parity_err), .fault_set(fault_set), .rsp_done(rsp_done),
      .rsp_cc(rsp_cc), .rsp_word(rsp_word), .io_reset_out(io_reset_out)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [6:0] opc, logic [2:0] fn,
                                      logic [2:0] ca, logic [2:0] ua, int salt);
      logic [7:0] junk = 8'(salt * 37 + 11);
      return {junk[0], opc, junk[7:1], fn, ca, ua, junk};
   endfunction

   task automatic send(logic [31:0] w, logic perr, logic [15:0] fs, string req);
      logic [6:0] opc = w[30:24];
      logic [2:0] fn  = w[16:14];
      logic [2:0] ca  = w[13:11];
      logic [2:0] ua  = w[10:8];
      logic rec;
      logic [2:0]  ecc;
      logic [31:0] ew;
      logic        erst;
      rec = (opc == 7'h4F) && (fn == 3'd1 || fn == 3'd2 || fn == 3'd3) &&
            (ca == my_cluster) && (ca == 3'd7 || ua == my_unit);
      ecc = !rec ? 3'b110 : perr ? 3'b101 : (fn != 3'd1 && st != 0) ? 3'b010 : 3'b000;
      ew   = (rec && fn != 3'd1) ? {st, st} : 32'h0;
      erst = rec && fn == 3'd1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_word = w; parity_err = perr; fault_set = fs;
      @(negedge clk);
      cmd_valid = 1'b0; parity_err = 1'b0; fault_set = '0;
      check(req, "done", 32'(rsp_done), 32'h1);
      check(req, "cc", 32'(rsp_cc), 32'(ecc));
      check(req, "word", rsp_word, ew);
      check(req, "io_reset", 32'(io_reset_out), 32'(erst));
      st = ((rec && fn == 3'd3) ? 16'h0 : st) | fs;
      last_cc = ecc; last_word = ew;
   endtask

   task automatic idle_check(int n, string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(req, "idle done", 32'(rsp_done), 32'h0);
         check(req, "idle io_reset", 32'(io_reset_out), 32'h0);
         check(req, "held cc", 32'(rsp_cc), 32'(last_cc));
         check(req, "held word", rsp_word, last_word);
      end
   endtask

   task automatic inject(logic [15:0] fs);
      @(negedge clk);
      fault_set = fs;
      @(negedge clk);
      fault_set = '0;
      st = st | fs;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "done", 32'(rsp_done), 32'h0);
      check("R10", "io_reset", 32'(io_reset_out), 32'h0);
      check("R10", "cc", 32'(rsp_cc), 32'h0);
      check("R10", "word", rsp_word, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "ready", 32'(cmd_ready), 32'h1);
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 1), 1'b0, 16'h0, "R10 status zero after reset");

      // R4: poll reports, does not clear
      inject(16'h0101);
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 2), 1'b0, 16'h0, "R4");
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 3), 1'b0, 16'h0, "R4");
      // R5: poll and clear
      send(mk(7'h4F, 3'd3, 3'd2, 3'd4, 4), 1'b0, 16'h0, "R5");
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 5), 1'b0, 16'h0, "R5");
      // R8: fault in same cycle as clear survives
      inject(16'h8001);
      send(mk(7'h4F, 3'd3, 3'd2, 3'd4, 6), 1'b0, 16'h0040, "R8");
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 7), 1'b0, 16'h0, "R8");
      // R3: reset pulse one cycle
      send(mk(7'h4F, 3'd1, 3'd2, 3'd4, 8), 1'b0, 16'h0, "R3");
      idle_check(2, "R3");
      // R7: parity on reset and on poll-clear; side effects still taken
      send(mk(7'h4F, 3'd1, 3'd2, 3'd4, 9), 1'b1, 16'h0, "R7");
      send(mk(7'h4F, 3'd3, 3'd2, 3'd4, 10), 1'b1, 16'h0, "R7");
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 11), 1'b0, 16'h0, "R7");
      // R1/R6: wrong opcode, bad operation, mismatched address; no side effect
      inject(16'h0F00);
      send(mk(7'h4E, 3'd3, 3'd2, 3'd4, 12), 1'b1, 16'h0, "R1");
      send(mk(7'h0F, 3'd1, 3'd2, 3'd4, 13), 1'b0, 16'h0, "R1");
      send(mk(7'h4F, 3'd7, 3'd2, 3'd4, 14), 1'b0, 16'h0, "R6");
      send(mk(7'h4F, 3'd3, 3'd2, 3'd5, 15), 1'b0, 16'h0, "R2");
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 16), 1'b0, 16'h0, "R6 status kept");
      // R9: back-to-back and hold
      send(mk(7'h4F, 3'd2, 3'd2, 3'd4, 17), 1'b0, 16'h0, "R9");
      send(mk(7'h4F, 3'd0, 3'd2, 3'd4, 18), 1'b0, 16'h0, "R9");
      idle_check(3, "R9");

      // Sweep: every cluster, unit and operation against several straps
      for (int s = 0; s < 3; s++) begin
         @(negedge clk);
         my_cluster = (s == 0) ? 3'd0 : (s == 1) ? 3'd7 : 3'd5;
         my_unit    = (s == 0) ? 3'd6 : (s == 1) ? 3'd2 : 3'd7;
         for (int i = 0; i < 512; i++) begin
            logic [15:0] fs;
            fs = ((i % 5) == 0) ? ((16'h1 << (i % 16)) | (16'h8000 >> (i % 3))) : 16'h0;
            send(mk(7'h4F, 3'(i), 3'(i >> 6), 3'(i >> 3), i), (i % 7) == 3, fs,
                 (3'(i >> 6) == 3'd7) ? "R2 sweep" : "R6 sweep");
            if ((i % 64) == 0) idle_check(1, "R9 sweep");
         end
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule